// File: doc/BRIEF.md
# MSI Vector Mask and Delivery Engine

This block sits between a device's interrupt sources and its outbound memory-write path. Device logic raises one-cycle requests on a per-vector request bitmap. The engine turns each legal, unmasked request into a message-signalled interrupt. A message is a 64-bit target address and a 32-bit data word, offered on a valid/ready channel. The capability register file keeps ownership of the enable bit, the requested vector count, the address, the programmed data and the mask word. The engine reads them as plain inputs and keeps the pending word itself, which it shows on an output so the register file can present it.

A request for a masked vector is parked in the pending word and no message goes out. A parked vector is replayed when its mask bit is cleared, or when the capability is written while it is enabled. A capability write also discards parked vectors beyond the enabled count. Several sources that are ready at once are sent lowest vector first, one message per accepted handshake.

Top module: `msi_vec_engine`

## Requirements
- R1: A request bit at or above the enabled vector count (2 to the power of the effective log count) is ignored: no message and no pending bit. While enabled, such a request raises `req_err` for exactly one cycle, in the cycle after the request.
- R2: With masking present and enabled, a request for a vector whose `cap_mask` bit is 1 sets that vector's bit in `pend_o` on the next clock and produces no message.
- R3: `msg_data[15:0]` equals `cap_data` with its low L bits cleared, ORed with the vector number, where L is the effective log count. `msg_data[31:16]` is zero.
- R4: With 64-bit support (`HAS_64`=1), `msg_addr` is `cap_addr`. Without it, `msg_addr` is `{32'h0, cap_addr[31:0]}`.
- R5: While enabled, a 1-to-0 change of a mask bit whose pending bit is set clears that pending bit and sends that vector's message. While disabled, pending bits are held and not sent.
- R6: A `cap_wr` pulse while enabled clears every pending bit at or above the enabled vector count.
- R7: The same `cap_wr` pulse sends every pending vector whose mask bit is 0, clearing its pending bit. These messages go out in ascending vector order.
- R8: With masking absent (`HAS_MASK`=0), `cap_mask` has no effect. Every legal request is sent and `pend_o` stays zero.
- R9: While `cap_en` is 0, requests are dropped. No message is started and no pending bit is set.
- R10: At most one message is outstanding. `msg_addr`, `msg_data` and `msg_vec` stay unchanged while `msg_valid` is high and `msg_ready` is low. After a handshake, `msg_valid` is low for at least one cycle.
- R11: A `cap_log_cnt` larger than log2(`NUM_VEC`) is clamped to log2(`NUM_VEC`). Every vector below `NUM_VEC` is then legal.
- R12: Legal, unmasked requests that arrive in the same cycle are each sent once, lowest vector number first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_en | input | 1 | Message interrupts enabled |
| cap_log_cnt | input | LOG_W | log2 of the enabled vector count, as programmed |
| cap_addr | input | 64 | Programmed message address |
| cap_data | input | 16 | Programmed message data |
| cap_mask | input | NUM_VEC | Per-vector mask bits |
| cap_wr | input | 1 | One-cycle pulse: the capability was written |
| irq_req | input | NUM_VEC | Per-vector request pulses from device logic |
| pend_o | output | NUM_VEC | Pending word |
| req_err | output | 1 | Out-of-range request seen in the previous cycle |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken by the write path |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_vec | output | VEC_W | Vector number of the offered message |

## Verification
Corrupted pending state becomes visible on `pend_o` one clock after the event that caused it. The error then shows as a vector that is lost or sent twice, once the next unmask or capability write replays it. A wrong arming or priority state shows as messages arriving out of ascending order at the very next handshake. A merge or address-select fault shows in the first message. The scoreboard compares every message's address and data against an ordered list of expected items. Pending bits and the error flag are sampled one cycle after each stimulus.

// File: rtl/msi_pkg.sv
package msi_pkg;
   localparam int MSG_ADDR_W  = 64;
   localparam int PROG_DATA_W = 16;
   localparam int MSG_DATA_W  = 32;

   typedef logic [MSG_ADDR_W-1:0]  msg_addr_t;
   typedef logic [MSG_DATA_W-1:0]  msg_data_t;
   typedef logic [PROG_DATA_W-1:0] prog_data_t;

   // Merge a vector index into programmed data under a log2 count.
   function automatic prog_data_t merge_vec(prog_data_t base, int unsigned lg,
                                            int unsigned vec);
      prog_data_t keep;
      keep = prog_data_t'('1) << lg;
      return (base & keep) | prog_data_t'(vec);
   endfunction
endpackage

// File: rtl/msi_count_ctl.sv
module msi_count_ctl #(
   parameter int NUM_VEC = 32,
   parameter int LOG_W   = 3
) (
   input  logic [LOG_W-1:0]   log_req,
   output logic [LOG_W-1:0]   log_eff,
   output logic [NUM_VEC-1:0] cnt_mask
);
   localparam int LOG_MAX = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 0;

   always_comb begin
      if (log_req > LOG_W'(LOG_MAX)) log_eff = LOG_W'(LOG_MAX);
      else                          log_eff = log_req;
   end

   for (genvar i = 0; i < NUM_VEC; i++) begin : g_lane
      assign cnt_mask[i] = ((32'(i)) >> log_eff) == 32'd0;
   end
endmodule

// File: rtl/msi_pend_arm.sv
module msi_pend_arm #(
   parameter int NUM_VEC  = 32,
   parameter bit HAS_MASK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               wr,
   input  logic [NUM_VEC-1:0] req,
   input  logic [NUM_VEC-1:0] mask_in,
   input  logic [NUM_VEC-1:0] cnt_mask,
   input  logic [NUM_VEC-1:0] taken,
   output logic [NUM_VEC-1:0] pend_o,
   output logic [NUM_VEC-1:0] arm_o,
   output logic               err_o
);
   logic [NUM_VEC-1:0] mask_eff, mask_q, pend_q, pend_n;
   logic [NUM_VEC-1:0] arm_q, arm_n, legal, rel, rel_sel;
   logic               err_q;

   assign legal = req & cnt_mask;

   always_comb begin
      pend_n  = pend_q;
      arm_n   = '0;
      rel     = '0;
      rel_sel = wr ? {NUM_VEC{1'b1}} : mask_q;
      if (en) begin
         if (wr) pend_n = pend_n & cnt_mask;
         rel    = pend_n & ~mask_eff & rel_sel;
         pend_n = (pend_n & ~rel) | (legal & mask_eff);
         arm_n  = (arm_q & ~taken) | rel | (legal & ~mask_eff);
      end
   end

   if (HAS_MASK) begin : g_mask
      assign mask_eff = mask_in;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
         end else begin
            pend_q <= pend_n;
            mask_q <= mask_eff;
         end
      end

      AST_MASKED_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
         (en && |(req & cnt_mask & mask_in)) |=>
         ((pend_q & $past(req & cnt_mask & mask_in)) == $past(req & cnt_mask & mask_in))); // R2
   end else begin : g_nomask
      assign mask_eff = '0;
      assign mask_q   = '0;
      assign pend_q   = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= '0;
         err_q <= 1'b0;
      end else begin
         arm_q <= arm_n;
         err_q <= en && |(req & ~cnt_mask);
      end
   end

   assign pend_o = pend_q;
   assign arm_o  = arm_q;
   assign err_o  = err_q;

   AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (en && |(req & ~cnt_mask)) |=> err_o); // R1
   AST_TRIM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wr) |=> ((pend_o & ~$past(cnt_mask)) == '0)); // R6
endmodule

// File: rtl/msi_lowest_pick.sv
module msi_lowest_pick #(
   parameter int NUM_VEC = 32,
   parameter int VEC_W   = 5
) (
   input  logic [NUM_VEC-1:0] cand,
   output logic [NUM_VEC-1:0] grant,
   output logic [VEC_W-1:0]   idx,
   output logic               any
);
   logic [NUM_VEC:0] below;

   assign below[0] = 1'b0;
   for (genvar i = 0; i < NUM_VEC; i++) begin : g_chain
      assign below[i+1] = below[i] | cand[i];
      assign grant[i]   = cand[i] & ~below[i];
   end
   assign any = below[NUM_VEC];

   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_VEC; i++) begin
         if (grant[i]) idx = idx | VEC_W'(i);
      end
   end
endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out
   import msi_pkg::*;
#(
   parameter int VEC_W  = 5,
   parameter int LOG_W  = 3,
   parameter bit HAS_64 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             any,
   input  logic [VEC_W-1:0] idx,
   input  logic [LOG_W-1:0] log_eff,
   input  msg_addr_t        cap_addr,
   input  prog_data_t       cap_data,
   input  logic             ready,
   output logic             take,
   output logic             valid,
   output msg_addr_t        addr_o,
   output msg_data_t        data_o,
   output logic [VEC_W-1:0] vec_o
);
   msg_addr_t  addr_sel;
   prog_data_t merged;
   logic       vld_q;

   if (HAS_64) begin : g_a64
      assign addr_sel = cap_addr;
   end else begin : g_a32
      assign addr_sel = {32'h0, cap_addr[31:0]};
   end

   assign merged = merge_vec(cap_data, int'(log_eff), int'(idx));
   assign take   = en && any && !vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         addr_o <= '0;
         data_o <= '0;
         vec_o  <= '0;
      end else if (take) begin
         vld_q  <= 1'b1;
         addr_o <= addr_sel;
         data_o <= {16'h0, merged};
         vec_o  <= idx;
      end else if (vld_q && ready) begin
         vld_q  <= 1'b0;
      end
   end

   assign valid = vld_q;

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !ready) |=> (vld_q && $stable(addr_o) && $stable(data_o) && $stable(vec_o))); // R10
   AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && ready) |=> !vld_q); // R10
   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vld_q) |-> $past(en)); // R9
endmodule

// File: rtl/msi_vec_engine.sv
module msi_vec_engine
   import msi_pkg::*;
#(
   parameter int NUM_VEC  = 32,
   parameter int LOG_W    = 3,
   parameter bit HAS_MASK = 1'b1,
   parameter bit HAS_64   = 1'b1,
   localparam int VEC_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cap_en,
   input  logic [LOG_W-1:0]       cap_log_cnt,
   input  logic [MSG_ADDR_W-1:0]  cap_addr,
   input  logic [PROG_DATA_W-1:0] cap_data,
   input  logic [NUM_VEC-1:0]     cap_mask,
   input  logic                   cap_wr,
   input  logic [NUM_VEC-1:0]     irq_req,
   output logic [NUM_VEC-1:0]     pend_o,
   output logic                   req_err,
   output logic                   msg_valid,
   input  logic                   msg_ready,
   output logic [MSG_ADDR_W-1:0]  msg_addr,
   output logic [MSG_DATA_W-1:0]  msg_data,
   output logic [VEC_W-1:0]       msg_vec
);
   if (NUM_VEC < 1 || NUM_VEC > 32 || (NUM_VEC & (NUM_VEC - 1)) != 0) begin : g_bad_num
      $error("NUM_VEC must be a power of two from 1 to 32");
   end
   if ((2 ** LOG_W) - 1 < ((NUM_VEC > 1) ? $clog2(NUM_VEC) : 0)) begin : g_bad_log
      $error("LOG_W too narrow for NUM_VEC");
   end

   logic [LOG_W-1:0]   log_eff;
   logic [NUM_VEC-1:0] cnt_mask, arm, grant, taken;
   logic [VEC_W-1:0]   idx;
   logic               any, take;

   msi_count_ctl #(.NUM_VEC(NUM_VEC), .LOG_W(LOG_W)) u_cnt (
      .log_req (cap_log_cnt),
      .log_eff (log_eff),
      .cnt_mask(cnt_mask)
   );

   msi_pend_arm #(.NUM_VEC(NUM_VEC), .HAS_MASK(HAS_MASK)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cap_en),
      .wr      (cap_wr),
      .req     (irq_req),
      .mask_in (cap_mask),
      .cnt_mask(cnt_mask),
      .taken   (taken),
      .pend_o  (pend_o),
      .arm_o   (arm),
      .err_o   (req_err)
   );

   msi_lowest_pick #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_pick (
      .cand (arm),
      .grant(grant),
      .idx  (idx),
      .any  (any)
   );

   assign taken = take ? grant : '0;

   msi_msg_out #(.VEC_W(VEC_W), .LOG_W(LOG_W), .HAS_64(HAS_64)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cap_en),
      .any     (any),
      .idx     (idx),
      .log_eff (log_eff),
      .cap_addr(cap_addr),
      .cap_data(cap_data),
      .ready   (msg_ready),
      .take    (take),
      .valid   (msg_valid),
      .addr_o  (msg_addr),
      .data_o  (msg_data),
      .vec_o   (msg_vec)
   );
endmodule

// File: tb/msi_vec_engine_tb_top.sv
module msi_vec_engine_tb_top;
   localparam int NV = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cap_en = 1'b0;
   logic [2:0]    cap_log_cnt = '0;
   logic [63:0]   cap_addr = 64'h0;
   logic [15:0]   cap_data = 16'h0;
   logic [NV-1:0] cap_mask = '0;
   logic          cap_wr = 1'b0;
   logic [NV-1:0] irq_req = '0, irq_req2 = '0;
   logic [NV-1:0] pend_o, pend2;
   logic          req_err, req_err2;
   logic          msg_valid, msg_valid2, msg_ready = 1'b1;
   logic [63:0]   msg_addr, msg_addr2;
   logic [31:0]   msg_data, msg_data2;
   logic [4:0]    msg_vec, msg_vec2;

   int nchk = 0, nfail = 0;
   bit done = 1'b0;
   logic [95:0] expq[$];
   logic [95:0] expq2[$];

   always #5 clk = ~clk;

   msi_vec_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_log_cnt(cap_log_cnt),
      .cap_addr(cap_addr), .cap_data(cap_data), .cap_mask(cap_mask), .cap_wr(cap_wr),
      .irq_req(irq_req), .pend_o(pend_o), .req_err(req_err), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data), .msg_vec(msg_vec));

   msi_vec_engine #(.HAS_MASK(1'b0), .HAS_64(1'b0)) dut_nm_i (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_log_cnt(cap_log_cnt),
      .cap_addr(cap_addr), .cap_data(cap_data), .cap_mask(cap_mask), .cap_wr(cap_wr),
      .irq_req(irq_req2), .pend_o(pend2), .req_err(req_err2), .msg_valid(msg_valid2),
      .msg_ready(1'b1), .msg_addr(msg_addr2), .msg_data(msg_data2), .msg_vec(msg_vec2));

   task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_data(logic [15:0] d, int lg, int v);
      logic [15:0] k;
      k = 16'hFFFF << lg;
      return {16'h0, (d & k) | 16'(v)};
   endfunction

   task automatic push(int lg, int v, bit wide);
      logic [63:0] a;
      a = wide ? cap_addr : {32'h0, cap_addr[31:0]};
      if (wide) expq.push_back({a, exp_data(cap_data, lg, v)});
      else      expq2.push_back({a, exp_data(cap_data, lg, v)});
   endtask

   task automatic pulse(logic [NV-1:0] v, bit second);
      @(negedge clk);
      if (second) irq_req2 = v; else irq_req = v;
      @(negedge clk);
      irq_req = '0;
      irq_req2 = '0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Scoreboard monitors: each sample with valid and ready high is one handshake.
   always begin
      @(negedge clk);
      #2;
      if (rst_n && msg_valid && msg_ready) begin
         if (expq.size() == 0) chk("R9 unexpected message", {msg_addr, msg_data}, 96'h0);
         else chk("R3 R4 R12 message", {msg_addr, msg_data}, expq.pop_front());
      end
      if (rst_n && msg_valid2) begin
         if (expq2.size() == 0) chk("R8 unexpected message", {msg_addr2, msg_data2}, 96'h0);
         else chk("R4 R8 message", {msg_addr2, msg_data2}, expq2.pop_front());
      end
   end

   initial begin
      logic [31:0] d1;
      idle(2);
      #1;
      chk("R10 reset valid", msg_valid, 0);
      chk("R2 reset pending", pend_o, 0);
      chk("R1 reset err", req_err, 0);
      @(negedge clk);
      rst_n = 1'b1;
      cap_en = 1'b1; cap_log_cnt = 3'd3;
      cap_addr = 64'h1234_5678_FEE0_1000; cap_data = 16'hAB30;
      idle(2);

      // R3: single vector, data merge under count 8
      push(3, 5, 1);
      pulse(32'h20, 0);
      idle(4);

      // R12, R10: three at once, ready low, ascending replay
      msg_ready = 1'b0;
      push(3, 0, 1); push(3, 2, 1); push(3, 6, 1);
      pulse(32'h45, 0);
      idle(2); #1;
      d1 = msg_data;
      chk("R12 lowest first vec", msg_vec, 0);
      idle(3); #1;
      chk("R10 held valid", msg_valid, 1);
      chk("R10 held data", msg_data, d1);
      msg_ready = 1'b1;
      idle(8);

      // R1: vector 9 out of range for count 8
      pulse(32'h200, 0);
      chk("R1 err pulse", req_err, 1);
      chk("R1 no pending", pend_o, 0);
      @(negedge clk);
      chk("R1 err one cycle", req_err, 0);
      idle(3);

      // R2: masked request parks
      cap_mask = 32'h10;
      pulse(32'h10, 0);
      chk("R2 pending set", pend_o, 32'h10);
      idle(2);
      chk("R2 no message", msg_valid, 0);

      // R8, R4: same mask on maskless 32-bit instance has no effect
      push(3, 4, 0);
      pulse(32'h10, 1);
      idle(4);
      chk("R8 pending stays zero", pend2, 0);

      // R5: unmask releases
      push(3, 4, 1);
      cap_mask = 32'h0;
      idle(5);
      chk("R5 pending cleared", pend_o, 0);

      // R9: disabled drops requests, unmasked and masked
      cap_en = 1'b0;
      pulse(32'h02, 0);
      cap_mask = 32'h08;
      pulse(32'h08, 0);
      idle(3);
      chk("R9 nothing parked", pend_o, 0);
      chk("R9 no message", msg_valid, 0);

      // R6, R7: park 1,3,5,9 at count 16, then shrink to 8 and write
      cap_en = 1'b1; cap_log_cnt = 3'd4; cap_mask = 32'h22A;
      @(negedge clk);
      pulse(32'h22A, 0);
      chk("R2 four parked", pend_o, 32'h22A);
      cap_en = 1'b0;
      @(negedge clk);
      cap_mask = 32'h0;
      idle(3);
      chk("R5 held while disabled", pend_o, 32'h22A);
      push(3, 1, 1); push(3, 3, 1); push(3, 5, 1);
      cap_en = 1'b1; cap_log_cnt = 3'd3; cap_wr = 1'b1;
      @(negedge clk);
      cap_wr = 1'b0;
      #1;
      chk("R6 R7 pending after write", pend_o, 0);
      idle(10);

      // R11: count 7 clamps to 5, vector 31 legal
      cap_log_cnt = 3'd7;
      push(5, 31, 1);
      pulse(32'h8000_0000, 0);
      chk("R11 no error", req_err, 0);
      idle(6);

      chk("R12 all delivered", expq.size(), 0);
      chk("R8 all delivered", expq2.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule